// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block holds the stack pointer of an 8-bit accumulator processor. The pointer can work in two ways. In byte mode it is a plain 8-bit register. In wide mode it becomes a 10-bit pointer: the two low bits of a separate extension register sit above the 8-bit pointer. The instruction decoder sends push, call, pop and return requests, each with a byte count. Software can also write the pointer byte, the extension byte and the wide-mode enable directly.

The pointer always names the last used location. A push therefore stores its first byte at the address one above the current top, and the block outputs that address as well as the top-of-stack address. Every update is registered and shows up at the ports one clock after the request. The stack RAM and the placement of the 1 KiB window in memory belong to the surrounding logic, not to this block.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 07h, the extension register reads 00h, wide mode is off and `stack_addr` is 007h.
- R2: A request with `op_kind` 00 (push) or 01 (call) raises the pointer by `op_count` one cycle later. A count of 0 leaves it unchanged. `push_addr` always equals the top address plus one, wrapped in the current mode.
- R3: A request with `op_kind` 10 (pop) or 11 (return) lowers the pointer by `op_count` one cycle later.
- R4: In wide mode, `stack_addr` is {extension[1:0], pointer[7:0]}.
- R5: In byte mode, bits 9:8 of `stack_addr` are 0, and push, call, pop and return leave the extension register unchanged.
- R6: In byte mode the pointer wraps modulo 256.
- R7: In wide mode, a carry or borrow out of the pointer byte goes into extension[1:0], and the 10-bit value wraps modulo 1024.
- R8: A write to the extension register stores only bits 1:0 of the written byte. Bits 7:2 of `ext_rd` always read 0.
- R9: If a pointer write or an extension write happens in the same cycle as a request, the write takes effect and the request is dropped.
- R10: A write of the wide-mode enable takes effect on the next cycle. A request in the same cycle still uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A stack request is present this cycle |
| op_kind | input | 2 | 00 push, 01 call, 10 pop, 11 return |
| op_count | input | 2 | Number of bytes moved |
| wr_ptr_en | input | 1 | Direct write of the pointer byte |
| wr_ptr_data | input | 8 | Value for the pointer byte |
| wr_ext_en | input | 1 | Direct write of the extension byte |
| wr_ext_data | input | 8 | Value for the extension byte (bits 1:0 kept) |
| wr_mode_en | input | 1 | Direct write of the wide-mode enable |
| wr_mode_data | input | 1 | New wide-mode enable |
| stack_addr | output | 10 | Address of the last used stack location |
| push_addr | output | 10 | Address the next pushed byte goes to |
| ptr_rd | output | 8 | Pointer byte read-back |
| ext_rd | output | 8 | Extension byte read-back |
| wide_rd | output | 1 | Wide-mode enable read-back |

## Verification
A wrong carry path or a wrong mode decision changes `stack_addr` and `push_addr` in the first cycle after the request. The bench compares every port after every request, so such a fault is caught one clock after it occurs. The costly mistakes are quiet ones: a byte-mode request that disturbs the extension bits, or a wrap that skips the extension. These stay hidden until wide mode is switched on. For that reason the sequence writes the extension while in byte mode, runs requests that wrap, and then switches mode and checks the joined address straight away.

// File: rtl/stkp_pkg.sv
package stkp_pkg;

    // Request kinds; bit 1 set means bytes are removed from the stack.
    typedef enum logic [1:0] {
        STK_PUSH = 2'b00,
        STK_CALL = 2'b01,
        STK_POP  = 2'b10,
        STK_RET  = 2'b11
    } stk_op_e;

    function automatic logic op_removes(input logic [1:0] kind);
        return kind[1];
    endfunction

endpackage

// File: rtl/stkp_step.sv
// Next-pointer arithmetic: adds or subtracts a byte count.
// In byte mode only the low field moves and the extension bits pass through.
module stkp_step #(
    parameter int PTR_W = 8,
    parameter int EXT_W = 2,
    parameter int CNT_W = 2
) (
    input  logic                     wide,
    input  logic                     remove,
    input  logic [CNT_W-1:0]         count,
    input  logic [PTR_W+EXT_W-1:0]   cur,
    output logic [PTR_W+EXT_W-1:0]   nxt
);
    localparam int ADDR_W = PTR_W + EXT_W;

    logic [ADDR_W-1:0] full_delta;
    logic [PTR_W-1:0]  low_delta;
    logic [ADDR_W-1:0] full_sum;
    logic [PTR_W-1:0]  low_sum;

    always_comb begin
        full_delta = ADDR_W'(count);
        low_delta  = PTR_W'(count);
        full_sum   = remove ? (cur - full_delta) : (cur + full_delta);
        low_sum    = remove ? (cur[PTR_W-1:0] - low_delta)
                            : (cur[PTR_W-1:0] + low_delta);
        if (wide) begin
            nxt = full_sum;
        end else begin
            nxt = {cur[ADDR_W-1:PTR_W], low_sum};
        end
    end

endmodule

// File: rtl/stkp_addr_gen.sv
// Builds the top-of-stack address and the address of the next push.
module stkp_addr_gen #(
    parameter int PTR_W = 8,
    parameter int EXT_W = 2
) (
    input  logic                   wide,
    input  logic [EXT_W-1:0]       ext,
    input  logic [PTR_W-1:0]       ptr,
    output logic [PTR_W+EXT_W-1:0] top_addr,
    output logic [PTR_W+EXT_W-1:0] next_addr
);
    localparam int ADDR_W = PTR_W + EXT_W;

    logic [ADDR_W-1:0] joined;
    logic [ADDR_W-1:0] bumped;

    assign joined = {ext, ptr};

    stkp_step #(.PTR_W(PTR_W), .EXT_W(EXT_W), .CNT_W(1)) u_bump (
        .wide   (wide),
        .remove (1'b0),
        .count  (1'b1),
        .cur    (joined),
        .nxt    (bumped)
    );

    always_comb begin
        if (wide) begin
            top_addr  = joined;
            next_addr = bumped;
        end else begin
            top_addr  = {{EXT_W{1'b0}}, ptr};
            next_addr = {{EXT_W{1'b0}}, bumped[PTR_W-1:0]};
        end
    end

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stkp_pkg::*;
#(
    parameter int               PTR_W     = 8,
    parameter int               EXT_W     = 2,
    parameter int               REG_W     = 8,
    parameter int               CNT_W     = 2,
    parameter logic [PTR_W-1:0] RESET_PTR = 'h07
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [1:0]             op_kind,
    input  logic [CNT_W-1:0]       op_count,
    input  logic                   wr_ptr_en,
    input  logic [PTR_W-1:0]       wr_ptr_data,
    input  logic                   wr_ext_en,
    input  logic [REG_W-1:0]       wr_ext_data,
    input  logic                   wr_mode_en,
    input  logic                   wr_mode_data,
    output logic [PTR_W+EXT_W-1:0] stack_addr,
    output logic [PTR_W+EXT_W-1:0] push_addr,
    output logic [PTR_W-1:0]       ptr_rd,
    output logic [REG_W-1:0]       ext_rd,
    output logic                   wide_rd
);
    localparam int ADDR_W = PTR_W + EXT_W;

    typedef struct packed {
        logic [EXT_W-1:0] ext;
        logic [PTR_W-1:0] ptr;
        logic             wide;
    } stk_state_t;

    stk_state_t        st_d, st_q;
    logic [ADDR_W-1:0] step_nxt;
    logic              any_write;

    stkp_step #(.PTR_W(PTR_W), .EXT_W(EXT_W), .CNT_W(CNT_W)) u_step (
        .wide   (st_q.wide),
        .remove (op_removes(op_kind)),
        .count  (op_count),
        .cur    ({st_q.ext, st_q.ptr}),
        .nxt    (step_nxt)
    );

    assign any_write = wr_ptr_en | wr_ext_en;

    always_comb begin
        st_d = st_q;
        if (any_write) begin
            if (wr_ptr_en) st_d.ptr = wr_ptr_data;
            if (wr_ext_en) st_d.ext = wr_ext_data[EXT_W-1:0];
        end else if (op_valid) begin
            {st_d.ext, st_d.ptr} = step_nxt;
        end
        if (wr_mode_en) st_d.wide = wr_mode_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ext  <= '0;
            st_q.ptr  <= RESET_PTR;
            st_q.wide <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    stkp_addr_gen #(.PTR_W(PTR_W), .EXT_W(EXT_W)) u_addr (
        .wide      (st_q.wide),
        .ext       (st_q.ext),
        .ptr       (st_q.ptr),
        .top_addr  (stack_addr),
        .next_addr (push_addr)
    );

    assign ptr_rd  = st_q.ptr;
    assign wide_rd = st_q.wide;

    generate
        if (REG_W > EXT_W) begin : g_ext_pad
            assign ext_rd = {{(REG_W-EXT_W){1'b0}}, st_q.ext};
        end else begin : g_ext_flat
            assign ext_rd = REG_W'(st_q.ext);
        end
    endgenerate

    // Assertions
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr_en |=> ptr_rd == $past(wr_ptr_data));

    assert_ext_low_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ext_en |=> ext_rd[EXT_W-1:0] == $past(wr_ext_data[EXT_W-1:0]));

    assert_byte_addr_high_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_rd |-> stack_addr[ADDR_W-1:PTR_W] == '0);

    assert_byte_ext_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_rd && op_valid && !any_write) |=> $stable(ext_rd));

    assert_byte_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_rd && op_valid && !op_kind[1] && !any_write)
        |=> ptr_rd == $past(ptr_rd) + PTR_W'($past(op_count)));

    assert_wide_pop_borrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_rd && op_valid && op_kind[1] && !any_write)
        |=> {ext_rd[EXT_W-1:0], ptr_rd}
            == $past({ext_rd[EXT_W-1:0], ptr_rd}) - ADDR_W'($past(op_count)));

endmodule

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [1:0] op_kind = 2'b00;
    logic [1:0] op_count = 2'b00;
    logic       wr_ptr_en = 1'b0;
    logic [7:0] wr_ptr_data = 8'h00;
    logic       wr_ext_en = 1'b0;
    logic [7:0] wr_ext_data = 8'h00;
    logic       wr_mode_en = 1'b0;
    logic       wr_mode_data = 1'b0;
    logic [9:0] stack_addr, push_addr;
    logic [7:0] ptr_rd, ext_rd;
    logic       wide_rd;

    always #2 clk = ~clk;

    stack_ptr_unit dut (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_kind(op_kind), .op_count(op_count),
        .wr_ptr_en(wr_ptr_en), .wr_ptr_data(wr_ptr_data),
        .wr_ext_en(wr_ext_en), .wr_ext_data(wr_ext_data),
        .wr_mode_en(wr_mode_en), .wr_mode_data(wr_mode_data),
        .stack_addr(stack_addr), .push_addr(push_addr),
        .ptr_rd(ptr_rd), .ext_rd(ext_rd), .wide_rd(wide_rd)
    );

    typedef struct {
        string tag;
        int    ptr;
        int    ext;
        int    wide;
        int    top;
        int    nxt;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    int m_ptr = 7, m_ext = 0, m_wide = 0;

    function automatic int top_of(int p, int e, int w);
        return w ? (e * 256 + p) : p;
    endfunction

    function automatic int next_of(int p, int e, int w);
        return w ? ((e * 256 + p + 1) % 1024) : ((p + 1) % 256);
    endfunction

    task automatic compare(string tag, int ep, int ee, int ew, int et, int en);
        total++;
        if (ptr_rd !== 8'(ep) || ext_rd !== 8'(ee) || wide_rd !== 1'(ew) ||
            stack_addr !== 10'(et) || push_addr !== 10'(en)) begin
            bad++;
            $display("FAIL %s: got ptr=%h ext=%h wide=%b top=%h nxt=%h exp ptr=%h ext=%h wide=%0d top=%h nxt=%h",
                     tag, ptr_rd, ext_rd, wide_rd, stack_addr, push_addr, ep, ee, ew, et, en);
        end
    endtask

    // driver: applies one cycle of stimulus and records the expected result
    task automatic drive(string tag, bit v, int kind, int cnt,
                         bit pw, int pd, bit ew, int ed, bit mw, bit md);
        exp_t e;
        int full;
        @(negedge clk);
        op_valid = v; op_kind = 2'(kind); op_count = 2'(cnt);
        wr_ptr_en = pw; wr_ptr_data = 8'(pd);
        wr_ext_en = ew; wr_ext_data = 8'(ed);
        wr_mode_en = mw; wr_mode_data = md;
        if (pw || ew) begin
            if (pw) m_ptr = pd & 255;
            if (ew) m_ext = ed & 3;
        end else if (v) begin
            if (m_wide != 0) begin
                full = m_ext * 256 + m_ptr;
                full = (kind >= 2) ? (full - cnt + 1024) % 1024 : (full + cnt) % 1024;
                m_ext = full / 256;
                m_ptr = full % 256;
            end else begin
                m_ptr = (kind >= 2) ? (m_ptr - cnt + 256) % 256 : (m_ptr + cnt) % 256;
            end
        end
        if (mw) m_wide = md;
        e.tag = tag; e.ptr = m_ptr; e.ext = m_ext; e.wide = m_wide;
        e.top = top_of(m_ptr, m_ext, m_wide);
        e.nxt = next_of(m_ptr, m_ext, m_wide);
        q.push_back(e);
    endtask

    // monitor: compares one cycle after each driven request
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                compare(e.tag, e.ptr, e.ext, e.wide, e.top, e.nxt);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung exp finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        compare("R1 reset state", 7, 0, 0, 7, 8);

        //          tag                     v kind cnt pw pd    ew ed    mw md
        drive("R2 push one",               1, 0, 1, 0, 0,    0, 0,    0, 0);
        drive("R2 call two",               1, 1, 2, 0, 0,    0, 0,    0, 0);
        drive("R2 zero count",             1, 0, 0, 0, 0,    0, 0,    0, 0);
        drive("R3 pop three",              1, 2, 3, 0, 0,    0, 0,    0, 0);
        drive("R3 ret two",                1, 3, 2, 0, 0,    0, 0,    0, 0);
        drive("R8 ext write keeps 1:0",    0, 0, 0, 0, 0,    1, 'hFE, 0, 0);
        drive("R5 byte addr ignores ext",  0, 0, 0, 1, 'hFE, 0, 0,    0, 0);
        drive("R6 byte push wraps",        1, 0, 3, 0, 0,    0, 0,    0, 0);
        drive("R5 ext untouched by push",  1, 1, 1, 0, 0,    0, 0,    0, 0);
        drive("R6 byte pop wraps",         1, 2, 3, 0, 0,    0, 0,    0, 0);
        drive("R8 ext write all ones",     0, 0, 0, 0, 0,    1, 'hFF, 0, 0);
        drive("R10 mode on with push",     1, 0, 1, 0, 0,    0, 0,    1, 1);
        drive("R4 wide address",           0, 0, 0, 1, 'hFF, 0, 0,    0, 0);
        drive("R7 wide push wraps 1024",   1, 0, 1, 0, 0,    0, 0,    0, 0);
        drive("R7 wide pop wraps back",    1, 3, 1, 0, 0,    0, 0,    0, 0);
        drive("R9 ext write beats pop",    1, 2, 3, 0, 0,    1, 'h00, 0, 0);
        drive("R7 wide carry into ext",    1, 1, 2, 0, 0,    0, 0,    0, 0);
        drive("R7 wide borrow from ext",   1, 2, 3, 0, 0,    0, 0,    0, 0);
        drive("R9 ptr write beats push",   1, 0, 3, 1, 'h40, 0, 0,    0, 0);
        drive("R9 both writes beat pop",   1, 3, 2, 1, 'h01, 1, 'h02, 0, 0);
        drive("R10 mode off, op wide",     1, 2, 2, 0, 0,    0, 0,    1, 0);
        drive("R5 byte pop keeps ext",     1, 2, 1, 0, 0,    0, 0,    0, 0);
        drive("R2 idle holds",             0, 0, 0, 0, 0,    0, 0,    0, 0);
        repeat (3) @(posedge clk);
        #1;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule